// File: doc/BRIEF.md
# Channel Physical Address Generator

This block holds the transfer state of one DMA channel: a 16-bit current address, a 16-bit remaining count and an 8-bit page value. From these it forms a 24-bit physical address and a pair of byte enables. A channel is either byte-wide or word-wide. A byte channel addresses one byte per transfer inside a 64K window. A word channel addresses one 16-bit word per transfer inside a 128K window.

The channel is programmed with a single-cycle load. The load carries the width, the auto-initialise flag, the page, the start address and the count. The count is written as the number of transfers minus one. Each transfer-done strobe moves the channel to its next transfer and shows the new address on the following cycle. The page never takes a carry, so the address wraps inside its window.

The terminal-count pulse marks the last transfer. After it, the channel either reloads its programmed start values or masks itself until it is loaded again.

Top module: `dma_addr_gen`

## Requirements
- R1: On a byte channel (`cfg_word`=0), `phys_addr[23:16]` equals the page and `phys_addr[15:0]` equals the current address.
- R2: On a word channel (`cfg_word`=1), `phys_addr[23:17]` equals page bits 7:1, `phys_addr[16:1]` equals the current address, and `phys_addr[0]` is 0. Page bit 0 has no effect on the output.
- R3: Each accepted strobe adds one to the current address, and the result appears on the next cycle. The address wraps from 0xFFFF to 0x0000 and the page bits of `phys_addr` stay unchanged.
- R4: Each accepted strobe subtracts one from `cur_count`. The strobe that finds the count at 0x0000 is the last one, so a loaded count of N gives N+1 transfers. In the cycle after that strobe, `term_count` is high for exactly one cycle.
- R5: With `cfg_auto`=1, the last transfer reloads the address and the count with the values from the most recent load, and the channel stays unmasked.
- R6: With `cfg_auto`=0, the last transfer sets `chan_masked`, and the count reads 0xFFFF. While the channel is masked, strobes change neither the address nor the count, and they raise no `term_count`.
- R7: `byte_en` is 2'b11 on a word channel. On a byte channel it is 2'b01 when address bit 0 is 0 and 2'b10 when it is 1.
- R8: After reset, `chan_masked`=1, `term_count`=0, `cur_count`=0, `phys_addr`=0 and `byte_en`=2'b01.
- R9: A load clears the mask and takes priority over a strobe in the same cycle. The loaded values appear on the next cycle, and no transfer is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Single-cycle pulse that programs the channel |
| cfg_word | input | 1 | 1 = word-wide channel, 0 = byte-wide channel |
| cfg_auto | input | 1 | Reload the start values at terminal count |
| cfg_page | input | 8 | Page value |
| cfg_addr | input | 16 | Start address |
| cfg_count | input | 16 | Number of transfers minus one |
| xfer_done | input | 1 | Transfer-done strobe |
| phys_addr | output | 24 | Physical address of the current transfer |
| byte_en | output | 2 | Byte-lane enables of the current transfer |
| cur_count | output | 16 | Remaining count register |
| term_count | output | 1 | One-cycle pulse after the last transfer |
| chan_masked | output | 1 | Channel is masked and ignores strobes |

## Verification
The properties assume that `cfg_load` and `xfer_done` are synchronous levels sampled at each rising edge, so that each cycle in which a strobe is high counts as one transfer. The stepping and holding checks also assume that a strobe arriving in the same cycle as a load is discarded. The stimulus changes every input on the falling edge and keeps each load and each strobe high for exactly one cycle. Strobes are sent to a masked channel on purpose, to show that they are ignored.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
    parameter int unsigned ADDR_W = 16;
    parameter int unsigned PAGE_W = 8;
    parameter int unsigned BE_W   = 2;
    localparam int unsigned PHYS_W = PAGE_W + ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] count;
        logic [ADDR_W-1:0] base_addr;
        logic [ADDR_W-1:0] base_count;
        logic [PAGE_W-1:0] page;
        logic              word;
        logic              auto_init;
        logic              masked;
        logic              tc;
    } chan_state_t;
endpackage

// File: rtl/dma_phys_map.sv
module dma_phys_map
    import dma_addr_pkg::*;
(
    input  logic              word_mode,
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] addr,
    output logic [PHYS_W-1:0] phys,
    output logic [BE_W-1:0]   be
);
    logic [PHYS_W-1:0] phys_byte;
    logic [PHYS_W-1:0] phys_word;

    // Byte window: the page supplies the bits above the address.
    // Word window: the address shifts up one place, and page bit 0 is dropped.
    assign phys_byte = {page, addr};
    assign phys_word = {page[PAGE_W-1:1], addr, 1'b0};

    always_comb begin
        if (word_mode) begin
            phys = phys_word;
            be   = '1;
        end else begin
            phys = phys_byte;
            be   = addr[0] ? BE_W'(2'b10) : BE_W'(2'b01);
        end
    end
endmodule

// File: rtl/dma_chan_ctr.sv
module dma_chan_ctr
    import dma_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_word,
    input  logic              cfg_auto,
    input  logic [PAGE_W-1:0] cfg_page,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_count,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] cur_count,
    output logic [PAGE_W-1:0] cur_page,
    output logic              word_mode,
    output logic              auto_mode,
    output logic              masked,
    output logic              tc
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    chan_state_t st_d, st_q;
    logic        last_xfer;

    assign last_xfer = (st_q.count == '0);

    always_comb begin
        st_d    = st_q;
        st_d.tc = 1'b0;
        if (cfg_load) begin
            st_d.addr       = cfg_addr;
            st_d.base_addr  = cfg_addr;
            st_d.count      = cfg_count;
            st_d.base_count = cfg_count;
            st_d.page       = cfg_page;
            st_d.word       = cfg_word;
            st_d.auto_init  = cfg_auto;
            st_d.masked     = 1'b0;
        end else if (xfer_done && !st_q.masked) begin
            // The address wraps inside its 16 bits; the page is never touched.
            st_d.addr  = st_q.addr + ONE;
            st_d.count = st_q.count - ONE;
            if (last_xfer) begin
                st_d.tc = 1'b1;
                if (st_q.auto_init) begin
                    st_d.addr  = st_q.base_addr;
                    st_d.count = st_q.base_count;
                end else begin
                    st_d.masked = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.masked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_addr  = st_q.addr;
    assign cur_count = st_q.count;
    assign cur_page  = st_q.page;
    assign word_mode = st_q.word;
    assign auto_mode = st_q.auto_init;
    assign masked    = st_q.masked;
    assign tc        = st_q.tc;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_word,
    input  logic              cfg_auto,
    input  logic [PAGE_W-1:0] cfg_page,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_count,
    input  logic              xfer_done,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [BE_W-1:0]   byte_en,
    output logic [ADDR_W-1:0] cur_count,
    output logic              term_count,
    output logic              chan_masked
);
    logic [ADDR_W-1:0] cur_addr;
    logic [PAGE_W-1:0] cur_page;
    logic              word_mode;
    logic              auto_mode;

    dma_chan_ctr ctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .cfg_word  (cfg_word),
        .cfg_auto  (cfg_auto),
        .cfg_page  (cfg_page),
        .cfg_addr  (cfg_addr),
        .cfg_count (cfg_count),
        .xfer_done (xfer_done),
        .cur_addr  (cur_addr),
        .cur_count (cur_count),
        .cur_page  (cur_page),
        .word_mode (word_mode),
        .auto_mode (auto_mode),
        .masked    (chan_masked),
        .tc        (term_count)
    );

    dma_phys_map map_i (
        .word_mode (word_mode),
        .page      (cur_page),
        .addr      (cur_addr),
        .phys      (phys_addr),
        .be        (byte_en)
    );
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk
    import dma_addr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load,
    input logic              xfer_done,
    input logic [PHYS_W-1:0] phys_addr,
    input logic [BE_W-1:0]   byte_en,
    input logic [ADDR_W-1:0] cur_count,
    input logic              term_count,
    input logic              chan_masked,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              word_mode,
    input logic              auto_mode
);
    // R3: an accepted strobe that is not the last transfer adds one to the address
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !chan_masked && !cfg_load && cur_count != '0)
        |=> cur_addr == ADDR_W'($past(cur_addr) + ADDR_W'(1)));

    // R4: terminal count only follows the last accepted transfer
    a_r4_tc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        term_count |-> $past(xfer_done && !chan_masked && !cfg_load && cur_count == '0));

    // R5: auto-initialise keeps the channel live
    a_r5_auto_live: assert property (@(posedge clk) disable iff (!rst_n)
        (term_count && auto_mode) |-> !chan_masked);

    // R6: without auto-initialise, terminal count masks the channel
    a_r6_mask_on_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (term_count && !auto_mode) |-> chan_masked);

    // R6: a masked channel holds its address and count
    a_r6_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_masked && !cfg_load) |=> ($stable(cur_addr) && $stable(cur_count)));

    // R2: a word channel never drives an odd address
    a_r2_word_even: assert property (@(posedge clk) disable iff (!rst_n)
        word_mode |-> (phys_addr[0] == 1'b0));

    // R7: a word channel enables both lanes; a byte channel enables exactly one
    a_r7_word_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        word_mode |-> (byte_en == '1));

    a_r7_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
        !word_mode |-> ($countones(byte_en) == 1));
endmodule

bind dma_addr_gen dma_addr_gen_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load    (cfg_load),
    .xfer_done   (xfer_done),
    .phys_addr   (phys_addr),
    .byte_en     (byte_en),
    .cur_count   (cur_count),
    .term_count  (term_count),
    .chan_masked (chan_masked),
    .cur_addr    (cur_addr),
    .word_mode   (word_mode),
    .auto_mode   (auto_mode)
);

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic        cfg_word = 1'b0;
    logic        cfg_auto = 1'b0;
    logic [7:0]  cfg_page = '0;
    logic [15:0] cfg_addr = '0;
    logic [15:0] cfg_count = '0;
    logic        xfer_done = 1'b0;
    logic [23:0] phys_addr;
    logic [1:0]  byte_en;
    logic [15:0] cur_count;
    logic        term_count;
    logic        chan_masked;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .cfg_auto(cfg_auto), .cfg_page(cfg_page), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .xfer_done(xfer_done), .phys_addr(phys_addr),
        .byte_en(byte_en), .cur_count(cur_count), .term_count(term_count),
        .chan_masked(chan_masked)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic w, input logic au, input logic [7:0] pg,
                        input logic [15:0] ad, input logic [15:0] cn, input logic strobe_too);
        @(negedge clk);
        cfg_load = 1'b1; cfg_word = w; cfg_auto = au;
        cfg_page = pg; cfg_addr = ad; cfg_count = cn;
        xfer_done = strobe_too;
        @(negedge clk);
        cfg_load = 1'b0; xfer_done = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R8 masked", 32'(chan_masked), 32'd1);
        check("R8 tc", 32'(term_count), 32'd0);
        check("R8 count", 32'(cur_count), 32'd0);
        check("R8 phys", 32'(phys_addr), 32'd0);
        check("R8 be", 32'(byte_en), 32'd1);
    endtask

    task automatic t_byte_map();
        load(1'b0, 1'b0, 8'h12, 16'h3456, 16'd3, 1'b0);
        check("R1 phys", 32'(phys_addr), 32'h123456);
        check("R7 even byte lane", 32'(byte_en), 32'd1);
        check("R9 unmasked", 32'(chan_masked), 32'd0);
        strobe();
        check("R3 step", 32'(phys_addr), 32'h123457);
        check("R7 odd byte lane", 32'(byte_en), 32'd2);
        check("R4 count", 32'(cur_count), 32'd2);
    endtask

    task automatic t_word_map();
        load(1'b1, 1'b0, 8'h13, 16'h8001, 16'd1, 1'b0);
        check("R2 phys", 32'(phys_addr), 32'h130002);
        check("R7 word lanes", 32'(byte_en), 32'd3);
        load(1'b1, 1'b0, 8'h12, 16'h8001, 16'd1, 1'b0);
        check("R2 page bit0 ignored", 32'(phys_addr), 32'h130002);
    endtask

    task automatic t_wrap();
        load(1'b0, 1'b0, 8'h40, 16'hFFFF, 16'd5, 1'b0);
        strobe();
        check("R3 byte wrap", 32'(phys_addr), 32'h400000);
        load(1'b1, 1'b0, 8'h41, 16'hFFFF, 16'd5, 1'b0);
        check("R2 word top", 32'(phys_addr), 32'h41FFFE);
        strobe();
        check("R3 word wrap", 32'(phys_addr), 32'h400000);
    endtask

    task automatic t_tc_mask();
        load(1'b0, 1'b0, 8'h00, 16'h0010, 16'd2, 1'b0);
        strobe();
        check("R4 no tc early", 32'(term_count), 32'd0);
        strobe();
        check("R4 count zero", 32'(cur_count), 32'd0);
        check("R4 no tc at zero", 32'(term_count), 32'd0);
        strobe();
        check("R4 tc pulse", 32'(term_count), 32'd1);
        check("R6 masked", 32'(chan_masked), 32'd1);
        check("R6 count", 32'(cur_count), 32'hFFFF);
        check("R6 addr", 32'(phys_addr), 32'h000013);
        idle();
        check("R4 tc one cycle", 32'(term_count), 32'd0);
        strobe();
        check("R6 ignored addr", 32'(phys_addr), 32'h000013);
        check("R6 ignored count", 32'(cur_count), 32'hFFFF);
        check("R6 ignored tc", 32'(term_count), 32'd0);
    endtask

    task automatic t_auto();
        load(1'b0, 1'b1, 8'h05, 16'h0100, 16'd1, 1'b0);
        strobe();
        check("R5 mid addr", 32'(phys_addr), 32'h050101);
        check("R5 mid count", 32'(cur_count), 32'd0);
        strobe();
        check("R5 tc", 32'(term_count), 32'd1);
        check("R5 live", 32'(chan_masked), 32'd0);
        check("R5 reload addr", 32'(phys_addr), 32'h050100);
        check("R5 reload count", 32'(cur_count), 32'd1);
        idle();
        check("R5 tc drops", 32'(term_count), 32'd0);
    endtask

    task automatic t_load_priority();
        load(1'b0, 1'b0, 8'h00, 16'h0000, 16'd0, 1'b0);
        strobe();
        check("R9 setup masked", 32'(chan_masked), 32'd1);
        load(1'b0, 1'b0, 8'hA5, 16'h0203, 16'd7, 1'b1);
        check("R9 loaded addr", 32'(phys_addr), 32'hA50203);
        check("R9 loaded count", 32'(cur_count), 32'd7);
        check("R9 unmasked", 32'(chan_masked), 32'd0);
        check("R9 no tc", 32'(term_count), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        t_reset();
        t_byte_map();
        t_word_map();
        t_wrap();
        t_tc_mask();
        t_auto();
        t_load_priority();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule